// File: doc/BRIEF.md
# Dual-Key Watchdog Timer

This block is a watchdog timer that counts up through a 15-bit register once per prescaled clock tick. Software sets a 7-bit reload value and then issues a start strobe. The start loads that value into the upper bits of the counter and zeroes the lower bits. From then on the timer runs, and no software write can stop it. If software does not refresh it, the counter reaches a fixed trip value. The block then drives an internal reset pulse and sets a sticky cause flag.

Refreshing takes two keys in a row. An arm strobe sets a flag that lives for exactly one cycle. A confirm strobe counts only while that flag is present, which means the cycle right after the arm strobe. A confirm at any other time does nothing. This makes it unlikely that stray code refreshes the timer by accident.

A watchdog reset does not stop the timer. When the pulse ends, the counter reloads and the timer keeps running. Only the external hardware reset stops it and clears the cause flag. The prescale select input sets both the tick rate and the length of the pulse.

Top module: `dual_key_watchdog`

## Requirements
- R1: After the external reset (`ext_rst_n` low), `wdt_rst` and `wdt_status` are 0. The timer stays stopped and never trips until a start strobe arrives.
- R2: A start strobe sampled at clock edge E loads the counter with {reload, 8'h00} and restarts the prescaler. The first tick falls D cycles later, where D is 2 when `div_sel`=0 and 16 when `div_sel`=1. `wdt_rst` rises at edge E + D*(0x7FFC - {reload,8'h00}).
- R3: A start strobe while the timer is running has no effect, so the trip time stays as scheduled.
- R4: An arm strobe at edge A followed by a confirm strobe at edge A+1 is a refresh. The counter reloads from the reload register, and the next trip comes D*(0x7FFC - {reload,8'h00}) cycles after edge A+1.
- R5: The arm flag lasts one cycle. A confirm in the same cycle as the arm strobe has no effect, and so does a confirm two cycles after it.
- R6: The reload register can be written at any time. A written value is used only at the next start, the next refresh or the end of the next pulse, and the current period keeps its schedule.
- R7: The watchdog reset begins on the tick that brings the counter to 15'h7FFC.
- R8: The reset pulse `wdt_rst` lasts 8 cycles when `div_sel`=0 and 128 cycles when `div_sel`=1, using the setting sampled at the trip.
- R9: When the pulse ends, the counter reloads and keeps counting. The next pulse rises D*(0x7FFC - {reload,8'h00}) cycles after the previous one fell.
- R10: `wdt_status` is set at the edge where the pulse begins and then holds. A `status_clr` strobe clears it. If the clear and a new trip fall in the same cycle, the set wins.
- R11: The external reset clears `wdt_status` and stops the timer, so no further pulse occurs until the next start.
- R12: A refresh sequence before the timer is started has no effect, and the timer stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External hardware reset, asynchronous, active low |
| div_sel | input | 1 | 0: divide by 2 and 8-cycle pulse; 1: divide by 16 and 128-cycle pulse |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_val | input | 7 | Reload value, loaded into the upper counter bits |
| arm_set | input | 1 | First refresh key |
| confirm_set | input | 1 | Second refresh key |
| status_clr | input | 1 | Clears the cause flag |
| start | input | 1 | Starts the timer if it is stopped |
| wdt_rst | output | 1 | Internal reset pulse |
| wdt_status | output | 1 | Sticky flag: a watchdog reset has occurred |

## Verification
Every cycle, the assertions check the following:
- A stopped timer never pulses, and the counter never passes the trip value.
- Each pulse starts exactly at 15'h7FFC, and a pulse never retriggers.
- The cause flag rises with the pulse and holds unless cleared.
- A refresh always follows an arm strobe and reloads the counter.
- The timer, once running, never stops on its own.

Only the bench scenarios can show the exact cycle counts:
- trip latency for each reload value and divider;
- pulse lengths of 8 and 128 cycles;
- the period after a pulse;
- a late or simultaneous confirm being ignored;
- a reload write not touching the current period;
- the set winning over a clear in the same cycle.

// File: rtl/wdt2_pkg.sv
`timescale 1ns/1ps
package wdt2_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_LOAD = 2'd1,
      CNT_STEP = 2'd2
   } cnt_act_e;
endpackage

// File: rtl/wdt2_prescaler.sv
`timescale 1ns/1ps
module wdt2_prescaler #(
   parameter int DIV_FAST = 2,
   parameter int DIV_SLOW = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic div_sel,
   output logic tick
);
   localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

   logic [PW-1:0] pre_q;
   logic [PW-1:0] lim;

   initial begin
      assert (DIV_FAST >= 1 && DIV_SLOW >= DIV_FAST)
         else $error("prescaler divisors out of range");
   end

   generate
      if (DIV_FAST == DIV_SLOW) begin : g_single
         assign lim = PW'(DIV_FAST - 1);
      end else begin : g_dual
         assign lim = div_sel ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
      end
   endgenerate

   assign tick = !clear && (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (clear)          pre_q <= '0;
      else if (pre_q >= lim)   pre_q <= '0;
      else                     pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/wdt2_refresh_gate.sv
`timescale 1ns/1ps
module wdt2_refresh_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic confirm_set,
   input  logic enable,
   output logic refresh
);
   logic arm_q;

   // arm flag lives for the single cycle after its strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= arm_set;
   end

   assign refresh = enable && arm_q && confirm_set;
endmodule

// File: rtl/wdt2_pulse_gen.sv
`timescale 1ns/1ps
module wdt2_pulse_gen #(
   parameter int PULSE_FAST = 8,
   parameter int PULSE_SLOW = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic long_sel,
   output logic active,
   output logic done
);
   localparam int PMAX = (PULSE_SLOW > PULSE_FAST) ? PULSE_SLOW : PULSE_FAST;
   localparam int PCW  = $clog2(PMAX + 1);

   logic [PCW-1:0] pcnt_q;
   logic [PCW-1:0] len;

   initial begin
      assert (PULSE_FAST >= 1 && PULSE_SLOW >= 1)
         else $error("pulse lengths must be positive");
   end

   generate
      if (PULSE_FAST == PULSE_SLOW) begin : g_fixed
         assign len = PCW'(PULSE_FAST);
      end else begin : g_sel
         assign len = long_sel ? PCW'(PULSE_SLOW) : PCW'(PULSE_FAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pcnt_q <= '0;
      else if (trip)           pcnt_q <= len;
      else if (pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
   end

   assign active = (pcnt_q != '0);
   assign done   = (pcnt_q == PCW'(1));

   p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> !active);
   p_pulse_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);
endmodule

// File: rtl/dual_key_watchdog.sv
`timescale 1ns/1ps
module dual_key_watchdog #(
   parameter int CNT_W      = 15,
   parameter int RL_W       = 7,
   parameter int TRIP_VALUE = 32'h7FFC,
   parameter int DIV_FAST   = 2,
   parameter int DIV_SLOW   = 16,
   parameter int PULSE_FAST = 8,
   parameter int PULSE_SLOW = 128
) (
   input  logic            clk,
   input  logic            ext_rst_n,
   input  logic            div_sel,
   input  logic            reload_we,
   input  logic [RL_W-1:0] reload_val,
   input  logic            arm_set,
   input  logic            confirm_set,
   input  logic            status_clr,
   input  logic            start,
   output logic            wdt_rst,
   output logic            wdt_status
);
   import wdt2_pkg::*;

   localparam int              LOW_W  = CNT_W - RL_W;
   localparam logic [CNT_W-1:0] TRIP_C = CNT_W'(TRIP_VALUE);
   localparam int              MAX_PRESET = ((1 << RL_W) - 1) << LOW_W;

   initial begin
      assert (RL_W >= 1 && LOW_W >= 1) else $error("reload width must be below counter width");
      assert (TRIP_VALUE < (1 << CNT_W)) else $error("trip value does not fit the counter");
      assert (TRIP_VALUE > MAX_PRESET) else $error("trip value must exceed every preset");
   end

   logic              running_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [RL_W-1:0]   rl_q;
   logic              status_q;
   logic [CNT_W-1:0]  preset;
   logic              start_fire, refresh, tick, trip;
   logic              p_active, p_done, pre_clear, counting;
   cnt_act_e          act;

   assign preset     = {rl_q, {LOW_W{1'b0}}};
   assign start_fire = start && !running_q;
   assign counting   = running_q && !p_active;

   wdt2_refresh_gate u_gate (
      .clk        (clk),
      .rst_n      (ext_rst_n),
      .arm_set    (arm_set),
      .confirm_set(confirm_set),
      .enable     (counting),
      .refresh    (refresh)
   );

   assign pre_clear = !running_q || start_fire || refresh || p_active;

   wdt2_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
      .clk    (clk),
      .rst_n  (ext_rst_n),
      .clear  (pre_clear),
      .div_sel(div_sel),
      .tick   (tick)
   );

   assign trip = counting && tick && !refresh && ((cnt_q + 1'b1) == TRIP_C);

   wdt2_pulse_gen #(.PULSE_FAST(PULSE_FAST), .PULSE_SLOW(PULSE_SLOW)) u_pulse (
      .clk     (clk),
      .rst_n   (ext_rst_n),
      .trip    (trip),
      .long_sel(div_sel),
      .active  (p_active),
      .done    (p_done)
   );

   always_comb begin
      if (start_fire || refresh || p_done) act = CNT_LOAD;
      else if (counting && tick)           act = CNT_STEP;
      else                                 act = CNT_HOLD;
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
         rl_q      <= '0;
         status_q  <= 1'b0;
      end else begin
         if (start_fire) running_q <= 1'b1;
         if (reload_we)  rl_q <= reload_val;
         case (act)
            CNT_LOAD: cnt_q <= preset;
            CNT_STEP: cnt_q <= cnt_q + 1'b1;
            default:  cnt_q <= cnt_q;
         endcase
         if (trip)            status_q <= 1'b1;
         else if (status_clr) status_q <= 1'b0;
      end
   end

   assign wdt_rst    = p_active;
   assign wdt_status = status_q;

   p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !running_q |-> !wdt_rst);
   p_start_loads_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (start && !running_q) |=> cnt_q == {$past(rl_q), {LOW_W{1'b0}}});
   p_refresh_loads_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      refresh |=> cnt_q == {$past(rl_q), {LOW_W{1'b0}}});
   p_refresh_needs_arm_r5: assert property (@(posedge clk) disable iff (!ext_rst_n)
      refresh |-> $past(arm_set));
   p_cnt_ceiling_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
      running_q |-> cnt_q <= TRIP_C);
   p_trip_value_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(wdt_rst) |-> cnt_q == TRIP_C);
   p_keeps_running_r9: assert property (@(posedge clk) disable iff (!ext_rst_n)
      running_q |=> running_q);
   p_status_on_trip_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(wdt_rst) |-> wdt_status);
   p_status_sticky_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (wdt_status && !status_clr) |=> wdt_status);
endmodule

// File: tb/tb_dual_key_watchdog.sv
`timescale 1ns/1ps
module tb_dual_key_watchdog;
   localparam int TRIP = 32'h7FFC;

   logic       clk = 1'b0;
   logic       ext_rst_n = 1'b0;
   logic       div_sel = 1'b0;
   logic       reload_we = 1'b0;
   logic [6:0] reload_val = '0;
   logic       arm_set = 1'b0;
   logic       confirm_set = 1'b0;
   logic       status_clr = 1'b0;
   logic       start = 1'b0;
   logic       wdt_rst;
   logic       wdt_status;

   int cyc = 0;
   int n_checks = 0;
   int n_fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dual_key_watchdog dut (
      .clk(clk), .ext_rst_n(ext_rst_n), .div_sel(div_sel),
      .reload_we(reload_we), .reload_val(reload_val),
      .arm_set(arm_set), .confirm_set(confirm_set),
      .status_clr(status_clr), .start(start),
      .wdt_rst(wdt_rst), .wdt_status(wdt_status)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int period(input int rl, input bit slow);
      return (slow ? 16 : 2) * (TRIP - rl * 256);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      ext_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      ext_rst_n = 1'b1;
   endtask

   task automatic write_rl(input int v);
      @(negedge clk);
      reload_we = 1'b1; reload_val = 7'(v);
      @(negedge clk);
      reload_we = 1'b0;
   endtask

   task automatic do_start(output int base);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base = cyc;
   endtask

   task automatic refresh_ok(output int base);
      @(negedge clk);
      arm_set = 1'b1;
      @(negedge clk);
      arm_set = 1'b0; confirm_set = 1'b1;
      @(negedge clk);
      confirm_set = 1'b0;
      base = cyc;
   endtask

   task automatic wait_rise(input int limit, output int at);
      at = -1;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (wdt_rst) begin
            at = cyc;
            break;
         end
      end
   endtask

   task automatic width(output int w);
      w = 0;
      while (wdt_rst) begin
         w++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 190000);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int b, at, w, p;
      do_reset();
      @(negedge clk);
      check(wdt_rst == 1'b0, "R1 reset rst", int'(wdt_rst), 0);
      check(wdt_status == 1'b0, "R1 reset status", int'(wdt_status), 0);

      // R12: refresh keys before any start do nothing
      write_rl(7'h7F);
      refresh_ok(b);
      wait_rise(700, at);
      check(at == -1, "R12 no start no trip", at, -1);

      // R2 R7 R8 R9 R10 sweep over divider and reload
      for (int s = 0; s < 2; s++) begin
         for (int rl = 7'h7C; rl <= 7'h7F; rl++) begin
            if (s == 1 && rl < 7'h7E) continue;
            do_reset();
            div_sel = 1'(s);
            write_rl(rl);
            do_start(b);
            p = period(rl, 1'(s));
            wait_rise(p + 50, at);
            check(at - b == p, "R2 R7 trip latency", at - b, p);
            check(wdt_status == 1'b1, "R10 status on trip", int'(wdt_status), 1);
            width(w);
            check(w == (s ? 128 : 8), "R8 pulse width", w, s ? 128 : 8);
            b = cyc;
            wait_rise(p + 50, at);
            check(at - b == p, "R9 period after pulse", at - b, p);
            width(w);
         end
      end
      div_sel = 1'b0;
      p = period(7'h7F, 1'b0);

      // R10 clear strobe
      @(negedge clk);
      status_clr = 1'b1;
      @(negedge clk);
      status_clr = 1'b0;
      check(wdt_status == 1'b0, "R10 clear", int'(wdt_status), 0);

      // R4 valid refresh
      do_reset(); write_rl(7'h7F); do_start(b);
      repeat (300) @(negedge clk);
      refresh_ok(b);
      wait_rise(p + 50, at);
      check(at - b == p, "R4 refresh reload", at - b, p);

      // R5 late confirm
      do_reset(); write_rl(7'h7F); do_start(b);
      repeat (100) @(negedge clk);
      @(negedge clk); arm_set = 1'b1;
      @(negedge clk); arm_set = 1'b0;
      @(negedge clk); confirm_set = 1'b1;
      @(negedge clk); confirm_set = 1'b0;
      wait_rise(p + 50, at);
      check(at - b == p, "R5 late confirm ignored", at - b, p);

      // R5 confirm in the same cycle as arm
      do_reset(); write_rl(7'h7F); do_start(b);
      repeat (100) @(negedge clk);
      @(negedge clk); arm_set = 1'b1; confirm_set = 1'b1;
      @(negedge clk); arm_set = 1'b0; confirm_set = 1'b0;
      wait_rise(p + 50, at);
      check(at - b == p, "R5 same-cycle confirm ignored", at - b, p);

      // R6 reload write mid-period: current period keeps schedule, next uses new value
      do_reset(); write_rl(7'h7F); do_start(b);
      repeat (50) @(negedge clk);
      write_rl(7'h7E);
      wait_rise(p + 50, at);
      check(at - b == p, "R6 current period unchanged", at - b, p);
      width(w);
      b = cyc;
      wait_rise(period(7'h7E, 1'b0) + 50, at);
      check(at - b == period(7'h7E, 1'b0), "R6 new value after pulse", at - b, period(7'h7E, 1'b0));
      width(w);

      // R6 new value taken at refresh
      do_reset(); write_rl(7'h7F); do_start(b);
      repeat (50) @(negedge clk);
      write_rl(7'h7E);
      refresh_ok(b);
      wait_rise(period(7'h7E, 1'b0) + 50, at);
      check(at - b == period(7'h7E, 1'b0), "R6 new value at refresh", at - b, period(7'h7E, 1'b0));

      // R3 second start ignored
      do_reset(); write_rl(7'h7F); do_start(b);
      repeat (200) @(negedge clk);
      do_start(at);
      wait_rise(p + 50, at);
      check(at - b == p, "R3 restart ignored", at - b, p);
      width(w);

      // R10 clear held across a trip: set wins
      status_clr = 1'b1;
      wait_rise(p + 50, at);
      check(wdt_status == 1'b1, "R10 set beats clear", int'(wdt_status), 1);
      @(negedge clk);
      status_clr = 1'b0;
      check(wdt_status == 1'b0, "R10 clear after trip", int'(wdt_status), 0);
      width(w);
      wait_rise(p + 50, at);
      check(wdt_status == 1'b1, "R10 set again", int'(wdt_status), 1);

      // R11 external reset stops timer and clears status
      do_reset();
      @(negedge clk);
      check(wdt_status == 1'b0, "R11 status cleared", int'(wdt_status), 0);
      wait_rise(700, at);
      check(at == -1, "R11 timer stopped", at, -1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule